// File: doc/BRIEF.md
# Serial Matrix Operand Loader

This block is the host side of a small matrix multiply engine. An external SPI master sends a command byte and then operand bytes. The block collects them into two square operand matrices, A and B, and tells the compute engine when both are complete. After the engine reports that its results are ready, the master can send a second command and read the accumulated results back on MISO. The serial pins are brought into the system clock domain through two-flop synchronisers, and every SPI event is taken from an edge detected in that domain. The SPI clock must therefore be a good deal slower than the system clock. The bench uses eight system clocks per SPI bit.

The multiply array is not part of this block. It reads the operand buses, and it drives the result bus and the done flag that this block reads.

Top module: `spiLoadFront`

## Requirements
- R1: SPI mode 0. While CS is low, MOSI is sampled on each rising SCK edge, and the most significant bit of each byte comes first.
- R2: `spiDone` goes high for exactly one system clock cycle for each byte completed while CS is low. This includes command bytes.
- R3: A frame whose first byte is 0x00 is a load frame. The next 16 bytes go into A and the 16 after that go into B, both in row-major order. Element i = row*4+col appears at bits [i*8+7:i*8] of `opAFlat` or `opBFlat`.
- R4: `loadDone` rises one cycle after the `spiDone` pulse of the 32nd operand byte and stays high. It is low before that byte. Receiving a new 0x00 command byte clears it.
- R5: Raising CS aborts the current frame. The next byte received after CS goes low is treated as a command byte again.
- R6: Bytes sent after the 33rd byte of a load frame, and every byte of a frame whose command is neither 0x00 nor 0x01, leave both operand buses and `loadDone` unchanged.
- R7: A frame whose command byte is 0x01, received while `compDone` is high, returns the results on MISO, MSB first, one byte per following SPI byte. Results go in row-major order from C[0][0]. Each 20-bit result takes three bytes, high byte first, and the top 4 bits of the first byte are zero. Result i is bits [i*20+19:i*20] of `resultFlat`. Bytes after the 48th read as 0x00.
- R8: MISO is low while CS is high, during load frames, and throughout a 0x01 frame whose command arrived while `compDone` was low.
- R9: After reset, `loadDone`, `spiDone` and `miso` are low and both operand buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock from master (asynchronous) |
| mosi | input | 1 | SPI data from master |
| csN | input | 1 | SPI chip select, active low |
| compDone | input | 1 | Engine reports results valid |
| resultFlat | input | 320 | 16 results of 20 bits, result i at [i*20 +: 20] |
| miso | output | 1 | SPI data to master |
| spiDone | output | 1 | One-cycle pulse per completed byte |
| loadDone | output | 1 | Both operand matrices loaded |
| opAFlat | output | 128 | Matrix A, element i at [i*8 +: 8] |
| opBFlat | output | 128 | Matrix B, element i at [i*8 +: 8] |

## Verification
The bench aborts frames part-way through at random points and then sends a full frame. A loader that kept its byte count across a CS rise would place the second frame's bytes one or more slots off. It sends a byte past the 33rd and a frame with an unknown command. A design that wrapped its operand index, or treated any command as a load, would corrupt A. It reads results back across the 48-byte boundary. An off-by-one in the byte/result stepping, or a missing zero pad, shows up as a wrong byte or a nonzero trailing byte. It also probes `loadDone` just before and just after the last operand byte, and sends a readback command while `compDone` is low. That catches a flag raised one byte early and results leaking out before they are valid.

// File: rtl/spiFrontPkg.sv
package spiFrontPkg;
  localparam int IDXW = 8;
  localparam logic [7:0] CMD_LOAD = 8'h00;
  localparam logic [7:0] CMD_READ = 8'h01;

  typedef enum logic [1:0] {M_CMD, M_LOAD, M_READ, M_SKIP} frameMode_t;

  typedef struct packed {
    logic            storeOp;
    logic [IDXW-1:0] opIdx;
    logic            loadTx;
    logic            txZero;
    logic [IDXW-1:0] txRes;
    logic [3:0]      txPart;
  } ctlStrb_t;
endpackage

// File: rtl/spiFrontDp.sv
module spiFrontDp
  import spiFrontPkg::*;
#(
  parameter int DIM = 4,
  parameter int RW  = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sck,
  input  logic                     mosi,
  input  logic                     csN,
  input  ctlStrb_t                 strb,
  input  logic [DIM*DIM*RW-1:0]    resultFlat,
  output logic [DIM*DIM*8-1:0]     opAFlat,
  output logic [DIM*DIM*8-1:0]     opBFlat,
  output logic                     byteDone,
  output logic [7:0]               rxByte,
  output logic                     csActive,
  output logic                     miso
);
  localparam int ELEMS = DIM * DIM;
  localparam int OPS   = 2 * ELEMS;
  localparam int OPIW  = $clog2(OPS);
  localparam int BPR   = (RW + 7) / 8;
  localparam int PADW  = BPR * 8;

  logic [2:0] sckS;
  logic [1:0] mosiS, csS;
  logic       sckRise;
  logic [2:0] bitCnt;
  logic [6:0] shiftReg;
  logic [7:0] txByte, txNext;
  logic [7:0] opMem [OPS];
  logic [RW-1:0]   selRes;
  logic [PADW-1:0] padded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      mosiS <= '0;
      csS   <= 2'b11;
    end else begin
      sckS  <= {sckS[1:0], sck};
      mosiS <= {mosiS[0], mosi};
      csS   <= {csS[0], csN};
    end
  end

  assign csActive = ~csS[1];
  assign sckRise  = sckS[1] & ~sckS[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shiftReg <= {shiftReg[5:0], mosiS[1]};
        bitCnt   <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          byteDone <= 1'b1;
          rxByte   <= {shiftReg, mosiS[1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < OPS; i++) opMem[i] <= '0;
    end else if (strb.storeOp) begin
      opMem[strb.opIdx[OPIW-1:0]] <= rxByte;
    end
  end

  for (genvar g = 0; g < ELEMS; g++) begin : gOpOut
    assign opAFlat[g*8 +: 8] = opMem[g];
    assign opBFlat[g*8 +: 8] = opMem[g+ELEMS];
  end

  always_comb begin
    int sel;
    selRes = '0;
    if (int'(strb.txRes) < ELEMS) selRes = resultFlat[int'(strb.txRes)*RW +: RW];
    padded = PADW'(selRes);
    sel    = BPR - 1 - int'(strb.txPart);
    if (sel < 0) sel = 0;
    txNext = padded[sel*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txByte <= '0;
    else if (!csActive)    txByte <= '0;
    else if (strb.loadTx)  txByte <= strb.txZero ? 8'h00 : txNext;
  end

  assign miso = csActive & txByte[~bitCnt];
endmodule

// File: rtl/spiFrontCtl.sv
module spiFrontCtl
  import spiFrontPkg::*;
#(
  parameter int DIM = 4,
  parameter int RW  = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  input  logic       csActive,
  input  logic       compDone,
  output ctlStrb_t   strb,
  output logic       loadDone
);
  localparam int ELEMS = DIM * DIM;
  localparam int OPS   = 2 * ELEMS;
  localparam int BPR   = (RW + 7) / 8;

  frameMode_t      mode;
  logic [IDXW-1:0] opCnt, resIdx;
  logic [3:0]      partIdx;
  logic            isLoadCmd, isReadCmd;

  assign isLoadCmd = (mode == M_CMD) && (rxByte == CMD_LOAD);
  assign isReadCmd = (mode == M_CMD) && (rxByte == CMD_READ) && compDone;

  always_comb begin
    strb = '0;
    if (byteDone) begin
      if (mode == M_LOAD) begin
        strb.storeOp = 1'b1;
        strb.opIdx   = opCnt;
      end
      if (isReadCmd) strb.loadTx = 1'b1;
      if (mode == M_READ) begin
        strb.loadTx = 1'b1;
        strb.txRes  = resIdx;
        strb.txPart = partIdx;
        strb.txZero = (resIdx == IDXW'(ELEMS));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= M_CMD;
      opCnt    <= '0;
      resIdx   <= '0;
      partIdx  <= '0;
      loadDone <= 1'b0;
    end else if (!csActive) begin
      mode <= M_CMD;
    end else if (byteDone) begin
      case (mode)
        M_CMD: begin
          if (isLoadCmd) begin
            mode     <= M_LOAD;
            opCnt    <= '0;
            loadDone <= 1'b0;
          end else if (isReadCmd) begin
            mode    <= M_READ;
            resIdx  <= (BPR == 1) ? IDXW'(1) : '0;
            partIdx <= (BPR == 1) ? 4'd0 : 4'd1;
          end else begin
            mode <= M_SKIP;
          end
        end
        M_LOAD: begin
          opCnt <= opCnt + 1'b1;
          if (opCnt == IDXW'(OPS - 1)) begin
            loadDone <= 1'b1;
            mode     <= M_SKIP;
          end
        end
        M_READ: begin
          if (resIdx != IDXW'(ELEMS)) begin
            if (partIdx == 4'(BPR - 1)) begin
              partIdx <= '0;
              resIdx  <= resIdx + 1'b1;
            end else begin
              partIdx <= partIdx + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spiLoadFront.sv
module spiLoadFront
  import spiFrontPkg::*;
#(
  parameter int DIM = 4,
  parameter int RW  = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sck,
  input  logic                  mosi,
  input  logic                  csN,
  input  logic                  compDone,
  input  logic [DIM*DIM*RW-1:0] resultFlat,
  output logic                  miso,
  output logic                  spiDone,
  output logic                  loadDone,
  output logic [DIM*DIM*8-1:0]  opAFlat,
  output logic [DIM*DIM*8-1:0]  opBFlat
);
  ctlStrb_t   strb;
  logic       byteDone, csActive;
  logic [7:0] rxByte;

  spiFrontDp #(.DIM(DIM), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN),
    .strb(strb), .resultFlat(resultFlat), .opAFlat(opAFlat), .opBFlat(opBFlat),
    .byteDone(byteDone), .rxByte(rxByte), .csActive(csActive), .miso(miso)
  );

  spiFrontCtl #(.DIM(DIM), .RW(RW)) u_ctl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxByte(rxByte),
    .csActive(csActive), .compDone(compDone), .strb(strb), .loadDone(loadDone)
  );

  assign spiDone = byteDone;
endmodule

// File: rtl/spiLoadFrontChk.sv
module spiLoadFrontChk #(
  parameter int DIM = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 miso,
  input logic                 spiDone,
  input logic                 loadDone,
  input logic [DIM*DIM*8-1:0] opAFlat,
  input logic [DIM*DIM*8-1:0] opBFlat
);
  AST_SPIDONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    spiDone |=> !spiDone); // R2

  AST_LOADDONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(spiDone)); // R4

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !miso); // R8

  AST_OPS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4))
      |=> ($stable(opAFlat) && $stable(opBFlat))); // R6

  AST_NO_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !spiDone); // R5
endmodule

bind spiLoadFront spiLoadFrontChk #(.DIM(DIM)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .spiDone(spiDone),
  .loadDone(loadDone), .opAFlat(opAFlat), .opBFlat(opBFlat)
);

// File: tb/spiLoadFront_bench.sv
module spiLoadFront_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int N = 16;
  localparam int RW = 20;

  logic clk = 0, rstN = 0, sck = 0, mosi = 0, csN = 1, compDone = 0;
  logic [N*RW-1:0] resultFlat = '0;
  logic miso, spiDone, loadDone;
  logic [N*8-1:0] opAFlat, opBFlat;

  int checks = 0, fails = 0, donePulses = 0, widePulses = 0;
  logic prevDone = 0;
  logic [7:0] aM [N], bM [N];
  logic [7:0] rxAcc;
  logic preLast;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiLoadFront u_spiLoadFront (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN),
    .compDone(compDone), .resultFlat(resultFlat), .miso(miso),
    .spiDone(spiDone), .loadDone(loadDone), .opAFlat(opAFlat), .opBFlat(opBFlat)
  );

  always @(posedge clk) begin
    if (spiDone) donePulses++;
    if (spiDone && prevDone) widePulses++;
    prevDone <= spiDone;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input int n);
    logic [23:0] padded;
    if (n >= 48) return 8'h00;
    padded = {4'b0, resultFlat[(n/3)*RW +: RW]};
    return padded[(2 - n%3)*8 +: 8];
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (6) @(negedge clk); csN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic loadFrame();
    logic [7:0] r;
    rxAcc = 0;
    xfer(8'h00, r);
    for (int i = 0; i < 2*N; i++) begin
      xfer(i < N ? aM[i] : bM[i-N], r);
      rxAcc |= r;
      if (i == 2*N-2) begin repeat (6) @(negedge clk); preLast = loadDone; end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic checkOps(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      if (opAFlat[i*8 +: 8] !== aM[i]) bad++;
      if (opBFlat[i*8 +: 8] !== bM[i]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int base;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!loadDone && !spiDone && !miso && opAFlat == 0 && opBFlat == 0, "R9 reset", {loadDone, spiDone, miso}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R1 R3: worked example, values up to 20 exercise MSB-first order
    for (int i = 0; i < N; i++) begin aM[i] = 8'(i + 1); bM[i] = 8'(i + 5); end
    aM[0] = 8'h81;
    base = donePulses;
    csLow(); loadFrame();
    chk(rxAcc == 0, "R8 miso quiet in load", rxAcc, 0);
    chk(preLast == 0, "R4 low before last byte", preLast, 0);
    chk(loadDone == 1, "R4 set after last byte", loadDone, 1);
    csHigh();
    checkOps("R3 R1 operand placement");
    chk(donePulses - base == 33, "R2 pulses per byte", donePulses - base, 33);
    chk(widePulses == 0, "R2 pulse width", widePulses, 0);

    // R5: abort mid-frame then full random frame
    for (int k = 0; k < 3; k++) begin
      int cut = 1 + int'($urandom_range(0, 30));
      csLow();
      xfer(8'h00, r);
      repeat (6) @(negedge clk);
      chk(loadDone == 0, "R4 cleared by new load", loadDone, 0);
      for (int i = 0; i < cut; i++) xfer(8'($urandom), r);
      csHigh();
      chk(loadDone == 0, "R5 aborted frame", loadDone, 0);
      for (int i = 0; i < N; i++) begin aM[i] = 8'($urandom); bM[i] = 8'($urandom); end
      csLow(); loadFrame();
      // R6: a byte past the 33rd
      xfer(8'hA5, r);
      csHigh();
      checkOps("R5 R6 frame after abort");
      chk(loadDone == 1, "R6 loadDone kept", loadDone, 1);
    end

    // R6: unknown command frame
    csLow();
    xfer(8'h5A, r);
    for (int i = 0; i < 2*N; i++) xfer(8'($urandom), r);
    csHigh();
    checkOps("R6 unknown command");
    chk(loadDone == 1, "R6 unknown cmd loadDone", loadDone, 1);

    // R8: readback before results valid
    for (int i = 0; i < N; i++) resultFlat[i*RW +: RW] = 20'($urandom);
    resultFlat[RW-1 -: RW] = 20'hFFFFF;
    compDone = 0;
    csLow(); xfer(8'h01, r);
    rxAcc = 0;
    for (int i = 0; i < 4; i++) begin xfer(8'h00, r); rxAcc |= r; end
    csHigh();
    chk(rxAcc == 0, "R8 read without compDone", rxAcc, 0);

    // R7: readback, twice with different result sets
    for (int p = 0; p < 2; p++) begin
      int bad = 0;
      if (p == 1) for (int i = 0; i < N; i++) resultFlat[i*RW +: RW] = 20'($urandom);
      compDone = 1;
      csLow(); xfer(8'h01, r);
      for (int n = 0; n < 50; n++) begin
        xfer(8'($urandom), r);
        if (r !== expRead(n)) begin
          bad++;
          if (bad == 1) chk(0, "R7 read byte", r, expRead(n));
        end
      end
      csHigh();
      chk(bad == 0, "R7 readback stream", bad, 0);
      checkOps("R6 readback leaves operands");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule